// File: doc/BRIEF.md
# Eight-bit PWM timer with two compare outputs

The block is an up-counter with two waveform generators that produce pulse-width modulated signals on two output pins, A and B. It runs in one of two waveform modes. In single-slope mode the counter climbs from zero to a ceiling value and wraps back to zero. In dual-slope mode the counter climbs to the ceiling, turns and descends back to zero, which gives symmetric pulses. The counter moves only on cycles where the `tick` input is high, so a prescaler outside the block sets the timer rate.

Each channel has an 8-bit compare value and a 2-bit action code. The code chooses what happens to the channel's pin when the count meets the compare value, and at the ends of the count range. The ceiling is either 255 or the channel A compare value, chosen by `top_sel`. Compare values pass through a holding register that is refreshed only at one end of the count range, so a write in mid-period cannot cut a pulse short. When a channel is not driven by its waveform, the pin repeats a plain port-data input.

Top module: `pwm_timer8`

## Requirements
- R1: After reset `count` is 0, `ovf` is 0, both waveform registers are 0, both compare holding registers are 255, and the counter is set to count upward.
- R2: On cycles with `tick` low, the counter, the direction, the waveform registers and the holding registers keep their values, and `ovf` is 0 in the next cycle.
- R3: In single-slope mode (`pc_mode`=0), a tick moves the count up by one. When the count equals the ceiling or 255, the tick takes it to 0 and `ovf` is high for exactly the next cycle. The ceiling is 255 when `top_sel`=0 and is the held A compare value when `top_sel`=1.
- R4: In dual-slope mode (`pc_mode`=1), ticks count up until the new count is at or above the ceiling, then count down. When a downward tick reaches 0, the direction turns to up and `ovf` is high for the next cycle.
- R5: The compare inputs are copied into the holding registers on the tick that wraps to 0 in single-slope mode, and on the tick that turns the count downward in dual-slope mode. Matches and the ceiling use the held values after that copy.
- R6: In single-slope mode, code 2'b10 sets the pin on the wrap to 0 and clears it on the tick whose new count equals the compare value. Code 2'b11 does the inverse. When both events fall on the same tick, the match action wins.
- R7: In single-slope mode with code 2'b1x, a compare value equal to the ceiling never counts as a match. Code 2'b10 then holds the pin high and code 2'b11 holds it low.
- R8: In dual-slope mode, a tick whose new count equals the compare value clears the pin for code 2'b10 if the counter now heads up, and sets it if it heads down. Code 2'b11 does the inverse.
- R9: In dual-slope mode with code 2'b1x, a compare value equal to the ceiling never counts as a match. Instead, the turning tick sets the pin for code 2'b10 and clears it for code 2'b11.
- R10: Code 2'b01 on channel A toggles the pin on each match when `top_sel`=1. With `top_sel`=0, channel A is disconnected. Code 2'b01 on channel B always leaves channel B disconnected.
- R11: A disconnected channel (code 2'b00, or code 2'b01 as given in R10) drives its pin directly from `port_a` or `port_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timer clock enable |
| pc_mode | input | 1 | 0 single-slope, 1 dual-slope |
| top_sel | input | 1 | 0 ceiling 255, 1 ceiling from compare A |
| cmp_a | input | 8 | Compare value, channel A |
| cmp_b | input | 8 | Compare value, channel B |
| mode_a | input | 2 | Pin action code, channel A |
| mode_b | input | 2 | Pin action code, channel B |
| port_a | input | 1 | Port data used when A is disconnected |
| port_b | input | 1 | Port data used when B is disconnected |
| count | output | 8 | Counter value |
| ovf | output | 1 | One-cycle pulse when the counter reaches 0 |
| out_a | output | 1 | Waveform pin A |
| out_b | output | 1 | Waveform pin B |

## Verification
Random ticks, codes and compare values are applied in both slope modes, with both ceiling choices. This shows whether match and end-of-range actions are tied to the correct count and direction. Compare values equal to the ceiling, and compare inputs rewritten on every cycle, separate the special-case rules and the holding-register timing from the normal match path. Runs with the toggle code and with disconnected codes, while the port inputs change at random, show whether the pin comes from the waveform or from the port.

// File: rtl/pwm_timer8.sv
`timescale 1ns/1ps
module pwm_timer8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         pc_mode,
  input  logic         top_sel,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [1:0]   mode_a,
  input  logic [1:0]   mode_b,
  input  logic         port_a,
  input  logic         port_b,
  output logic [W-1:0] count,
  output logic         ovf,
  output logic         out_a,
  output logic         out_b
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt, a_buf, b_buf;
  logic dir, ovf_r, wave_a, wave_b;

  wire [W-1:0] top_cur = top_sel ? a_buf : MAXV;
  wire [W-1:0] up_n    = (cnt == MAXV) ? cnt : cnt + 1'b1;
  wire [W-1:0] dn_n    = (cnt == '0) ? cnt : cnt - 1'b1;
  wire         f_wrap  = (cnt == top_cur) || (cnt == MAXV);
  wire         pc_turn = pc_mode && dir && (up_n >= top_cur);
  wire [W-1:0] nxt     = pc_mode ? (dir ? up_n : dn_n) : (f_wrap ? '0 : cnt + 1'b1);
  wire         bot_ev  = pc_mode ? (!dir && nxt == '0) : f_wrap;
  wire         load    = pc_mode ? pc_turn : f_wrap;
  wire [W-1:0] a_n     = load ? cmp_a : a_buf;
  wire [W-1:0] b_n     = load ? cmp_b : b_buf;
  wire [W-1:0] top_n   = top_sel ? a_n : MAXV;
  wire         dir_n   = pc_mode ? (pc_turn ? 1'b0 : (bot_ev ? 1'b1 : dir)) : 1'b1;

  function automatic logic wave_next(
    input logic w, input logic [1:0] m, input logic [W-1:0] ocr, input logic tog_ok,
    input logic [W-1:0] nx, input logic [W-1:0] tp, input logic pc, input logic up,
    input logic bot, input logic topev);
    logic special, hit, r;
    special = m[1] && (ocr == tp);
    hit     = (nx == ocr) && !special;
    r       = w;
    if (m == 2'b01) begin
      if (tog_ok && hit) r = ~w;
    end else if (m[1]) begin
      if (pc) begin
        if (hit)                   r = up ? m[0] : ~m[0];
        else if (special && topev) r = ~m[0];
      end else begin
        if (bot) r = ~m[0];
        if (hit) r = m[0];
      end
    end
    return r;
  endfunction

  wire wa_n = wave_next(wave_a, mode_a, a_n, top_sel, nxt, top_n, pc_mode, dir_n, bot_ev, pc_turn);
  wire wb_n = wave_next(wave_b, mode_b, b_n, 1'b0,    nxt, top_n, pc_mode, dir_n, bot_ev, pc_turn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir    <= 1'b1;
      a_buf  <= MAXV;
      b_buf  <= MAXV;
      wave_a <= 1'b0;
      wave_b <= 1'b0;
      ovf_r  <= 1'b0;
    end else begin
      ovf_r <= tick && bot_ev;
      if (tick) begin
        cnt    <= nxt;
        dir    <= dir_n;
        a_buf  <= a_n;
        b_buf  <= b_n;
        wave_a <= wa_n;
        wave_b <= wb_n;
      end
    end
  end

  wire con_a = mode_a[1] || (mode_a == 2'b01 && top_sel);
  wire con_b = mode_b[1];

  assign count = cnt;
  assign ovf   = ovf_r;
  assign out_a = con_a ? wave_a : port_a;
  assign out_b = con_b ? wave_b : port_b;
endmodule

module pwm_timer8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         pc_mode,
  input logic [W-1:0] count,
  input logic         ovf,
  input logic         wave_a,
  input logic         wave_b
);
  a_r2_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  a_r2_hold_wave: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(wave_a) && $stable(wave_b)));
  a_r2_no_ovf_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !ovf);
  a_r3_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> count == '0);
  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pc_mode) |=> (count == $past(count) + 1'b1 || count == $past(count) - 1'b1
                           || count == $past(count)));
endmodule

bind pwm_timer8 pwm_timer8_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pc_mode(pc_mode),
  .count(count), .ovf(ovf), .wave_a(wave_a), .wave_b(wave_b)
);

// File: tb/pwm_timer8_test.sv
`timescale 1ns/1ps
module pwm_timer8_test;
  logic clk = 0, rst_n = 0, tick = 0, pc_mode = 0, top_sel = 0, port_a = 0, port_b = 0;
  logic [7:0] cmp_a = 8'hFF, cmp_b = 8'h80;
  logic [1:0] mode_a = 2'b10, mode_b = 2'b10;
  wire [7:0] count;
  wire ovf, out_a, out_b;
  int total = 0, bad = 0;
  int m_cnt, m_dir, m_a, m_b, m_wa, m_wb, m_ovf;

  pwm_timer8 uut (.clk(clk), .rst_n(rst_n), .tick(tick), .pc_mode(pc_mode), .top_sel(top_sel),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .mode_a(mode_a), .mode_b(mode_b), .port_a(port_a),
    .port_b(port_b), .count(count), .ovf(ovf), .out_a(out_a), .out_b(out_b));

  always #2.5 clk = ~clk;

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int wv(int w, int m, int ocr, int tog, int nx, int tp, int pc, int up, int bot, int tev);
    int sp, hit, lo, r;
    sp  = (m >= 2 && ocr == tp) ? 1 : 0;
    hit = (nx == ocr && sp == 0) ? 1 : 0;
    lo  = m & 1;
    if (m == 1) return (tog != 0 && hit != 0) ? 1 - w : w;
    if (m < 2) return w;
    if (pc != 0) begin
      if (hit != 0) return (up != 0) ? lo : 1 - lo;
      if (sp != 0 && tev != 0) return 1 - lo;
      return w;
    end
    r = w;
    if (bot != 0) r = 1 - lo;
    if (hit != 0) r = lo;
    return r;
  endfunction

  task automatic mstep();
    int topc, nx, turn, bot, ld, an, bn, tn, nd;
    topc = top_sel ? m_a : 255;
    turn = 0;
    if (pc_mode) begin
      if (m_dir != 0) begin
        nx = (m_cnt == 255) ? 255 : m_cnt + 1;
        turn = (nx >= topc) ? 1 : 0;
      end else nx = (m_cnt == 0) ? 0 : m_cnt - 1;
      bot = (m_dir == 0 && nx == 0) ? 1 : 0;
      ld  = turn;
      nd  = (turn != 0) ? 0 : ((bot != 0) ? 1 : m_dir);
    end else begin
      bot = (m_cnt == topc || m_cnt == 255) ? 1 : 0;
      nx  = (bot != 0) ? 0 : m_cnt + 1;
      ld  = bot;
      nd  = 1;
    end
    an = (ld != 0) ? int'(cmp_a) : m_a;
    bn = (ld != 0) ? int'(cmp_b) : m_b;
    tn = top_sel ? an : 255;
    m_wa = wv(m_wa, mode_a, an, top_sel, nx, tn, pc_mode, nd, bot, turn);
    m_wb = wv(m_wb, mode_b, bn, 0, nx, tn, pc_mode, nd, bot, turn);
    m_cnt = nx; m_dir = nd; m_a = an; m_b = bn; m_ovf = bot;
  endtask

  function automatic int exp_a();
    return (mode_a >= 2 || (mode_a == 1 && top_sel)) ? m_wa : int'(port_a);
  endfunction
  function automatic int exp_b();
    return (mode_b >= 2) ? m_wb : int'(port_b);
  endfunction

  task automatic check_all(string tag);
    chk(tag, "count", count, m_cnt);
    chk(tag, "ovf", ovf, m_ovf);
    chk(tag, "out_a", out_a, exp_a());
    chk(tag, "out_b", out_b, exp_b());
  endtask

  task automatic new_cmps();
    if (top_sel) begin
      cmp_a = 8'(6 + $urandom % 30);
      cmp_b = 8'($urandom % (int'(cmp_a) + 2));
    end else begin
      cmp_a = 8'($urandom);
      cmp_b = 8'($urandom);
    end
  endtask

  task automatic do_reset(bit pc, bit ts, logic [1:0] ma, logic [1:0] mb);
    @(negedge clk);
    rst_n = 0; tick = 0; pc_mode = pc; top_sel = ts; mode_a = ma; mode_b = mb;
    new_cmps();
    @(negedge clk);
    m_cnt = 0; m_dir = 1; m_a = 255; m_b = 255; m_wa = 0; m_wb = 0; m_ovf = 0;
    check_all("R1");
    rst_n = 1;
  endtask

  task automatic run_phase(int n, string tag, int kind);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all(tag);
      tick = (kind == 9) ? 1'b0 : (($urandom % 4) != 0);
      port_a = 1'($urandom); port_b = 1'($urandom);
      case (kind)
        0: begin
          if ($urandom % 32 == 0) begin mode_a = 2'(2 + $urandom % 2); mode_b = 2'(2 + $urandom % 2); end
          if ($urandom % 16 == 0) new_cmps();
        end
        1: begin
          if ($urandom % 32 == 0) begin mode_a = 2'(2 + $urandom % 2); mode_b = 2'(2 + $urandom % 2); end
          cmp_b = top_sel ? cmp_a : 8'hFF;
        end
        2: if ($urandom % 64 == 0) new_cmps();
        3: begin mode_a = 2'($urandom % 2); mode_b = 2'($urandom % 2); end
        4: cmp_b = 8'($urandom);
        default: ;
      endcase
      if (tick) mstep(); else m_ovf = 0;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset(0, 1, 2'b10, 2'b11);
    run_phase(12, "R2", 9);
    run_phase(3000, "R3 R6", 0);
    do_reset(0, 0, 2'b10, 2'b10);
    run_phase(3000, "R3 R6", 0);
    do_reset(0, 1, 2'b10, 2'b11);
    run_phase(1500, "R7", 1);
    do_reset(0, 0, 2'b10, 2'b11);
    run_phase(2500, "R7", 1);
    do_reset(1, 1, 2'b10, 2'b11);
    run_phase(3000, "R4 R8", 0);
    do_reset(1, 0, 2'b11, 2'b10);
    run_phase(3000, "R4 R8", 0);
    do_reset(1, 1, 2'b10, 2'b10);
    run_phase(1500, "R9", 1);
    do_reset(1, 0, 2'b11, 2'b10);
    run_phase(2500, "R9", 1);
    do_reset(0, 1, 2'b01, 2'b01);
    run_phase(1500, "R10", 2);
    do_reset(1, 1, 2'b01, 2'b01);
    run_phase(1500, "R10", 2);
    do_reset(0, 0, 2'b00, 2'b00);
    run_phase(800, "R11 R10", 3);
    do_reset(0, 0, 2'b10, 2'b10);
    run_phase(2000, "R5", 4);
    do_reset(1, 0, 2'b10, 2'b11);
    run_phase(2000, "R5", 4);
    @(negedge clk);
    check_all("R5");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule